// File: doc/BRIEF.md
# Packet Buffer Page Manager

This block keeps the books for a shared packet memory divided into 256-byte pages. It tracks which packet numbers are in use, how many pages each one holds, and how many pages remain free. It does not store packet data. A host sends 8-bit commands to it. The top three bits of a command select an operation: allocate a multi-page packet, enqueue a packet for transmit, drop or free the packet at the head of the receive list, clear the transmit-side lists, or reset the whole manager.

Three packet-number lists sit inside the block. The transmit queue feeds the transmit engine. The completion list holds packets whose transmission the host must still acknowledge. The receive list holds packets that the receive engine has filled. The transmit engine strobes when it takes a packet and when it finishes one. The receive engine strobes to claim pages for an incoming frame. A host allocation that cannot be served at once stays pending. It is retried every cycle, and the block pulses a done flag when it is finally granted.

Top module: `pkt_buf_mmu`

## Requirements
- R1: After reset the memory-info word is {free pages, total pages} with both equal to TOTAL_PAGES, the FIFO-ports word is 0x8080, the allocation result is 0x80, the command readback is 0x00 and the transmit queue is empty.
- R2: Command readback is {last command bits 7:1, busy}. Busy (bit 0) is 1 for exactly the one cycle after an accepted write, and the command executes in that cycle. A write while busy is ignored.
- R3: Opcode 0x20 (bits 7:5 = 001) with bits 2:0 = pages−1 grants the lowest unused packet number when enough free pages and a number exist. The allocation result then holds that number with bit 7 clear, the free pages drop by the count, and the done flag pulses for one cycle.
- R4: A host allocation that cannot be granted sets the allocation result to 0x80 and stays pending. It is granted in the first later cycle in which enough resources exist, and the done flag pulses when it is.
- R5: Opcode 0xC0 appends the packet number on the enqueue input to the transmit queue. The engine sees the head in arrival order, and a take strobe removes the head.
- R6: A completion strobe with success while auto-release is on returns the packet's pages and adds no completion entry. Any other completion pushes the packet number into the completion list, which reads in FIFO-ports bits 6:0 with an empty flag in bit 7.
- R7: A completion-acknowledge strobe removes the head of the completion list and returns that packet's pages.
- R8: A receive request (pages−1 on its own input) grants a packet number that appears in FIFO-ports bits 14:8, with an empty flag in bit 15. If it cannot be granted, a drop pulse follows. A receive request takes priority over a host allocation executing in the same cycle; that host allocation then becomes pending.
- R9: Opcode 0x80 removes the receive head without returning its pages. Opcode 0xA0 removes it and returns its pages.
- R10: Opcode 0xE0 empties the transmit queue and the completion list and leaves the free page count unchanged.
- R11: Opcode 0x40 returns all pages, empties all three lists, clears a pending allocation and sets the allocation result to 0x80.
- R12: The memory-info word carries total pages in bits 7:0 and free pages in bits 15:8.
- R13: Opcodes 0x00 and 0x60 change no state apart from the command readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command byte |
| cmd_rdata | output | 8 | Command readback with busy in bit 0 |
| enq_pkt | input | 6 | Packet number used by the enqueue command |
| auto_release | input | 1 | Free successfully sent packets automatically |
| alloc_result | output | 8 | Allocated packet number, or 0x80 on failure |
| alloc_done | output | 1 | One-cycle pulse on a granted host allocation |
| fifo_ports | output | 16 | Receive head/empty (15:8), completion head/empty (7:0) |
| mem_info | output | 16 | Free pages (15:8), total pages (7:0) |
| txq_pkt | output | 6 | Transmit queue head |
| txq_valid | output | 1 | Transmit queue not empty |
| tx_pop | input | 1 | Transmit engine takes the queue head |
| tx_done | input | 1 | Transmit engine finished a packet |
| tx_ok | input | 1 | Finished packet was sent successfully |
| tx_done_pkt | input | 6 | Number of the finished packet |
| comp_pop | input | 1 | Host acknowledges the completion head |
| rx_req | input | 1 | Receive engine requests pages |
| rx_pages_m1 | input | 3 | Pages requested minus one |
| rx_drop | output | 1 | Pulse when a receive request was refused |

## Verification
If the slot map or the page counter goes wrong, the error first shows in mem_info. It appears on the cycle after the faulty grant or release, because every allocation and every release moves the free-page byte by a known amount. A wrong list pointer shows in fifo_ports or txq_pkt on the cycle after the push or pop, as a wrong head or a wrong empty flag. A broken retry path shows only when pages come back: alloc_result must change, and alloc_done must pulse, exactly one cycle after the release edge.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int PKT_W = 6;
  localparam int PGF_W = 3;
  localparam int CNT_W = PGF_W + 1;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_RSVD    = 3'd3,
    OP_RX_DROP = 3'd4,
    OP_RX_FREE = 3'd5,
    OP_TX_ENQ  = 3'd6,
    OP_TX_RST  = 3'd7
  } mmu_op_e;
endpackage

// File: rtl/mmu_pkt_fifo.sv
module mmu_pkt_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][W-1:0] mem_q, mem_n;
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             do_push, do_pop;

  assign empty = (cnt_q == '0);
  assign dout  = empty ? '0 : mem_q[rp_q];

  always_comb begin
    do_push = push && (cnt_q != CW'(DEPTH));
    do_pop  = pop && !empty;
    mem_n   = mem_q;
    wp_n    = wp_q;
    rp_n    = rp_q;
    cnt_n   = cnt_q;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) begin
        mem_n[wp_q] = din;
        wp_n = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      end
      if (do_pop)
        rp_n = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_n;
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // R9
  fifo_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/mmu_cmd_reg.sv
module mmu_cmd_reg
  import mmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       exec,
  output mmu_op_e    op,
  output logic [CNT_W-1:0] pages
);
  logic [7:0] cmd_q, cmd_n;
  logic       busy_q, busy_n;

  always_comb begin
    cmd_n  = cmd_q;
    busy_n = 1'b0;
    if (wr && !busy_q) begin
      cmd_n  = wdata;
      busy_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_n;
      busy_q <= busy_n;
    end
  end

  assign rdata = {cmd_q[7:1], busy_q};
  assign exec  = busy_q;
  assign op    = mmu_op_e'(cmd_q[7:5]);
  assign pages = {1'b0, cmd_q[PGF_W-1:0]} + 1'b1;

  // R2
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
endmodule

// File: rtl/mmu_page_pool.sv
module mmu_page_pool
  import mmu_pkg::*;
#(
  parameter int NUM_PKTS    = 16,
  parameter int TOTAL_PAGES = 32,
  parameter int NFREE       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         a_req,
  input  logic [CNT_W-1:0]             a_pages,
  input  logic                         b_req,
  input  logic [CNT_W-1:0]             b_pages,
  output logic                         a_grant,
  output logic                         b_grant,
  output logic [PKT_W-1:0]             grant_pkt,
  input  logic [NFREE-1:0]             free_v,
  input  logic [NFREE-1:0][PKT_W-1:0]  free_pkt,
  output logic [7:0]                   free_pages
);
  localparam int SLOT_W = $clog2(NUM_PKTS);

  logic [NUM_PKTS-1:0]            valid_q, valid_n, clr_mask, set_mask;
  logic [NUM_PKTS-1:0][CNT_W-1:0] pg_q, pg_n;
  logic [7:0]                     free_q, free_n, ret_pages;
  logic [CNT_W-1:0]               take;
  logic                           slot_found;
  logic [SLOT_W-1:0]              slot_idx;

  always_comb begin
    slot_found = 1'b0;
    slot_idx   = '0;
    for (int s = NUM_PKTS - 1; s >= 0; s--) begin
      if (!valid_q[s]) begin
        slot_found = 1'b1;
        slot_idx   = SLOT_W'(s);
      end
    end
  end

  assign a_grant   = a_req && slot_found && (free_q >= 8'(a_pages));
  assign b_grant   = b_req && !a_req && slot_found && (free_q >= 8'(b_pages));
  assign grant_pkt = PKT_W'(slot_idx);
  assign take      = a_grant ? a_pages : (b_grant ? b_pages : '0);

  always_comb begin
    logic hit;
    ret_pages = '0;
    for (int s = 0; s < NUM_PKTS; s++) begin
      hit = 1'b0;
      for (int k = 0; k < NFREE; k++)
        hit = hit | (free_v[k] && (free_pkt[k] == PKT_W'(s)));
      clr_mask[s] = valid_q[s] && hit;
      set_mask[s] = (a_grant || b_grant) && (slot_idx == SLOT_W'(s));
      if (clr_mask[s]) ret_pages = ret_pages + 8'(pg_q[s]);
    end
  end

  always_comb begin
    valid_n = valid_q;
    pg_n    = pg_q;
    free_n  = free_q;
    if (clear) begin
      valid_n = '0;
      free_n  = 8'(TOTAL_PAGES);
    end else begin
      valid_n = (valid_q & ~clr_mask) | set_mask;
      free_n  = free_q + ret_pages - 8'(take);
      for (int s = 0; s < NUM_PKTS; s++)
        if (set_mask[s]) pg_n[s] = take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      pg_q    <= '0;
      free_q  <= 8'(TOTAL_PAGES);
    end else begin
      valid_q <= valid_n;
      pg_q    <= pg_n;
      free_q  <= free_n;
    end
  end

  assign free_pages = free_q;

  // R12
  free_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= 8'(TOTAL_PAGES));

  // R11
  pool_idle_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q == '0) |-> (free_q == 8'(TOTAL_PAGES)));

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_grant && b_grant));
endmodule

// File: rtl/pkt_buf_mmu.sv
module pkt_buf_mmu
  import mmu_pkg::*;
#(
  parameter int NUM_PKTS    = 16,
  parameter int TOTAL_PAGES = 32,
  parameter int FIFO_DEPTH  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_wdata,
  output logic [7:0] cmd_rdata,
  input  logic [5:0] enq_pkt,
  input  logic       auto_release,
  output logic [7:0] alloc_result,
  output logic       alloc_done,
  output logic [15:0] fifo_ports,
  output logic [15:0] mem_info,
  output logic [5:0] txq_pkt,
  output logic       txq_valid,
  input  logic       tx_pop,
  input  logic       tx_done,
  input  logic       tx_ok,
  input  logic [5:0] tx_done_pkt,
  input  logic       comp_pop,
  input  logic       rx_req,
  input  logic [2:0] rx_pages_m1,
  output logic       rx_drop
);
  localparam int NFREE = 3;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic             exec;
  mmu_op_e          op;
  logic [CNT_W-1:0] cmd_pages;

  mmu_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_i), .wr(cmd_wr), .wdata(cmd_wdata),
    .rdata(cmd_rdata), .exec(exec), .op(op), .pages(cmd_pages)
  );

  logic ex_alloc, ex_reset, ex_rxdrop, ex_rxfree, ex_enq, ex_txrst;
  assign ex_alloc  = exec && (op == OP_ALLOC);
  assign ex_reset  = exec && (op == OP_RESET);
  assign ex_rxdrop = exec && (op == OP_RX_DROP);
  assign ex_rxfree = exec && (op == OP_RX_FREE);
  assign ex_enq    = exec && (op == OP_TX_ENQ);
  assign ex_txrst  = exec && (op == OP_TX_RST);

  logic             pend_q, pend_n;
  logic [CNT_W-1:0] pend_pg_q, pend_pg_n;
  logic [7:0]       res_q, res_n;
  logic             done_q, done_n, drop_q, drop_n;

  logic             a_req, b_req, a_grant, b_grant;
  logic [CNT_W-1:0] b_pages, rx_pages;
  logic [PKT_W-1:0] grant_pkt;
  logic [7:0]       free_pages;

  logic [PKT_W-1:0] rx_head, comp_head;
  logic             rx_empty, comp_empty, txq_empty;
  logic [NFREE-1:0]            free_v;
  logic [NFREE-1:0][PKT_W-1:0] free_pkt;
  logic             auto_free;

  assign rx_pages = {1'b0, rx_pages_m1} + 1'b1;
  assign a_req    = rx_req && !ex_reset;
  assign b_req    = !ex_reset && (ex_alloc || pend_q);
  assign b_pages  = ex_alloc ? cmd_pages : pend_pg_q;
  assign auto_free = tx_done && tx_ok && auto_release;

  assign free_v[0]   = ex_rxfree && !rx_empty;
  assign free_pkt[0] = rx_head;
  assign free_v[1]   = comp_pop && !comp_empty;
  assign free_pkt[1] = comp_head;
  assign free_v[2]   = auto_free;
  assign free_pkt[2] = tx_done_pkt;

  mmu_page_pool #(
    .NUM_PKTS(NUM_PKTS), .TOTAL_PAGES(TOTAL_PAGES), .NFREE(NFREE)
  ) u_pool (
    .clk(clk), .rst_n(rst_i), .clear(ex_reset),
    .a_req(a_req), .a_pages(rx_pages), .b_req(b_req), .b_pages(b_pages),
    .a_grant(a_grant), .b_grant(b_grant), .grant_pkt(grant_pkt),
    .free_v(free_v), .free_pkt(free_pkt), .free_pages(free_pages)
  );

  mmu_pkt_fifo #(.DEPTH(FIFO_DEPTH), .W(PKT_W)) u_txq (
    .clk(clk), .rst_n(rst_i), .clr(ex_reset || ex_txrst),
    .push(ex_enq), .din(enq_pkt), .pop(tx_pop),
    .dout(txq_pkt), .empty(txq_empty)
  );

  mmu_pkt_fifo #(.DEPTH(FIFO_DEPTH), .W(PKT_W)) u_comp (
    .clk(clk), .rst_n(rst_i), .clr(ex_reset || ex_txrst),
    .push(tx_done && !auto_free), .din(tx_done_pkt), .pop(comp_pop),
    .dout(comp_head), .empty(comp_empty)
  );

  mmu_pkt_fifo #(.DEPTH(FIFO_DEPTH), .W(PKT_W)) u_rxf (
    .clk(clk), .rst_n(rst_i), .clr(ex_reset),
    .push(a_grant), .din(grant_pkt), .pop(ex_rxdrop || ex_rxfree),
    .dout(rx_head), .empty(rx_empty)
  );

  always_comb begin
    pend_n    = pend_q;
    pend_pg_n = pend_pg_q;
    res_n     = res_q;
    done_n    = 1'b0;
    drop_n    = 1'b0;
    if (ex_reset) begin
      pend_n = 1'b0;
      res_n  = 8'h80;
    end else begin
      drop_n = rx_req && !a_grant;
      if (b_grant) begin
        pend_n = 1'b0;
        res_n  = {2'b00, grant_pkt};
        done_n = 1'b1;
      end else if (ex_alloc) begin
        pend_n    = 1'b1;
        pend_pg_n = cmd_pages;
        res_n     = 8'h80;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pend_q    <= 1'b0;
      pend_pg_q <= '0;
      res_q     <= 8'h80;
      done_q    <= 1'b0;
      drop_q    <= 1'b0;
    end else begin
      pend_q    <= pend_n;
      pend_pg_q <= pend_pg_n;
      res_q     <= res_n;
      done_q    <= done_n;
      drop_q    <= drop_n;
    end
  end

  assign alloc_result = res_q;
  assign alloc_done   = done_q;
  assign rx_drop      = drop_q;
  assign txq_valid    = !txq_empty;
  assign mem_info     = {free_pages, 8'(TOTAL_PAGES)};
  assign fifo_ports   = {rx_empty, 1'b0, rx_head, comp_empty, 1'b0, comp_head};

  // R3
  done_has_pkt_chk: assert property (@(posedge clk) disable iff (!rst_i)
    alloc_done |-> !alloc_result[7]);

  // R11
  mmu_reset_chk: assert property (@(posedge clk) disable iff (!rst_i)
    ex_reset |=> (mem_info[15:8] == 8'(TOTAL_PAGES)) && (fifo_ports == 16'h8080)
                 && !txq_valid && (alloc_result == 8'h80));

  // R10
  txrst_pages_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ex_txrst && !tx_done && !comp_pop && !rx_req && !pend_q) |=> $stable(free_pages));
endmodule

// File: tb/pkt_buf_mmu_test.sv
module pkt_buf_mmu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] cmd_rdata;
  logic [5:0] enq_pkt = '0;
  logic auto_release = 1'b0;
  logic [7:0] alloc_result;
  logic alloc_done;
  logic [15:0] fifo_ports, mem_info;
  logic [5:0] txq_pkt;
  logic txq_valid;
  logic tx_pop = 1'b0, tx_done = 1'b0, tx_ok = 1'b0;
  logic [5:0] tx_done_pkt = '0;
  logic comp_pop = 1'b0, rx_req = 1'b0;
  logic [2:0] rx_pages_m1 = '0;
  logic rx_drop;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pkt_buf_mmu uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .enq_pkt(enq_pkt), .auto_release(auto_release),
    .alloc_result(alloc_result), .alloc_done(alloc_done),
    .fifo_ports(fifo_ports), .mem_info(mem_info), .txq_pkt(txq_pkt),
    .txq_valid(txq_valid), .tx_pop(tx_pop), .tx_done(tx_done), .tx_ok(tx_ok),
    .tx_done_pkt(tx_done_pkt), .comp_pop(comp_pop), .rx_req(rx_req),
    .rx_pages_m1(rx_pages_m1), .rx_drop(rx_drop)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic [7:0] c);
    cmd_wdata = c;
    cmd_wr = 1'b1;
    step();
    cmd_wr = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 mem_info", mem_info, 16'h2020);
    chk("R1 fifo_ports", fifo_ports, 16'h8080);
    chk("R1 alloc_result", 16'(alloc_result), 16'h0080);
    chk("R1 cmd_rdata", 16'(cmd_rdata), 16'h0000);
    chk("R1 txq_valid", 16'(txq_valid), 16'h0000);
    chk("R12 total pages byte", 16'(mem_info[7:0]), 16'h0020);
  endtask

  task automatic t_busy();
    cmd_wdata = 8'h00;
    cmd_wr = 1'b1;
    step();
    chk("R2 busy set", 16'(cmd_rdata), 16'h0001);
    cmd_wdata = 8'h20;
    step();
    cmd_wr = 1'b0;
    chk("R2 busy clear, write ignored", 16'(cmd_rdata), 16'h0000);
    chk("R2 ignored alloc left pages", mem_info, 16'h2020);
    chk("R13 nop result", 16'(alloc_result), 16'h0080);
  endtask

  task automatic t_alloc();
    do_cmd(8'h22);
    chk("R3 first pkt", 16'(alloc_result), 16'h0000);
    chk("R3 done pulse", 16'(alloc_done), 16'h0001);
    chk("R3 free after 3 pages", mem_info, 16'h1D20);
    chk("R2 readback", 16'(cmd_rdata), 16'h0022);
    do_cmd(8'h20);
    chk("R3 second pkt", 16'(alloc_result), 16'h0001);
    chk("R3 free after 1 page", mem_info, 16'h1C20);
  endtask

  task automatic t_enqueue();
    enq_pkt = 6'd1; do_cmd(8'hC0);
    enq_pkt = 6'd0; do_cmd(8'hC0);
    chk("R5 head valid", 16'(txq_valid), 16'h0001);
    chk("R5 head first", 16'(txq_pkt), 16'h0001);
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
    chk("R5 head second", 16'(txq_pkt), 16'h0000);
    chk("R5 still valid", 16'(txq_valid), 16'h0001);
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
    chk("R5 queue drained", 16'(txq_valid), 16'h0000);
  endtask

  task automatic t_txdone();
    auto_release = 1'b0; tx_ok = 1'b1; tx_done_pkt = 6'd1; tx_done = 1'b1;
    step(); tx_done = 1'b0;
    chk("R6 completion entry", fifo_ports, 16'h8001);
    chk("R6 pages kept", mem_info, 16'h1C20);
    comp_pop = 1'b1; step(); comp_pop = 1'b0;
    chk("R7 completion popped", fifo_ports, 16'h8080);
    chk("R7 pages returned", mem_info, 16'h1D20);
    auto_release = 1'b1; tx_done_pkt = 6'd0; tx_done = 1'b1;
    step(); tx_done = 1'b0;
    chk("R6 auto-release frees", mem_info, 16'h2020);
    chk("R6 auto-release no entry", fifo_ports, 16'h8080);
    do_cmd(8'h20);
    chk("R3 reuse lowest", 16'(alloc_result), 16'h0000);
    tx_ok = 1'b0; tx_done = 1'b1;
    step(); tx_done = 1'b0;
    chk("R6 failed send queued", fifo_ports, 16'h8000);
    chk("R6 failed send keeps pages", mem_info, 16'h1F20);
    auto_release = 1'b0;
  endtask

  task automatic t_txreset();
    enq_pkt = 6'd0; do_cmd(8'hC0);
    chk("R10 queue loaded", 16'(txq_valid), 16'h0001);
    do_cmd(8'hE0);
    chk("R10 queue empty", 16'(txq_valid), 16'h0000);
    chk("R10 completion empty", fifo_ports, 16'h8080);
    chk("R10 pages unchanged", mem_info, 16'h1F20);
    do_cmd(8'h60);
    chk("R13 reserved op pages", mem_info, 16'h1F20);
    chk("R13 reserved op result", 16'(alloc_result), 16'h0000);
    chk("R13 reserved op lists", fifo_ports, 16'h8080);
  endtask

  task automatic t_rx();
    do_cmd(8'h40);
    chk("R11 reset pages", mem_info, 16'h2020);
    chk("R11 reset result", 16'(alloc_result), 16'h0080);
    rx_pages_m1 = 3'd1; rx_req = 1'b1; step();
    chk("R8 rx head", fifo_ports, 16'h0080);
    chk("R8 rx pages", mem_info, 16'h1E20);
    rx_pages_m1 = 3'd0; step(); rx_req = 1'b0;
    chk("R8 head unchanged", fifo_ports, 16'h0080);
    chk("R8 second rx pages", mem_info, 16'h1D20);
    do_cmd(8'h80);
    chk("R9 drop pops", fifo_ports, 16'h0180);
    chk("R9 drop keeps pages", mem_info, 16'h1D20);
    do_cmd(8'hA0);
    chk("R9 free pops", fifo_ports, 16'h8080);
    chk("R9 free returns pages", mem_info, 16'h1E20);
  endtask

  task automatic t_collision();
    do_cmd(8'h40);
    cmd_wdata = 8'h20; cmd_wr = 1'b1; step();
    cmd_wr = 1'b0; rx_req = 1'b1; rx_pages_m1 = 3'd0; step();
    rx_req = 1'b0;
    chk("R8 rx wins", fifo_ports, 16'h0080);
    chk("R8 host pending", 16'(alloc_result), 16'h0080);
    chk("R8 no done yet", 16'(alloc_done), 16'h0000);
    step();
    chk("R4 retry grant", 16'(alloc_result), 16'h0001);
    chk("R4 retry done", 16'(alloc_done), 16'h0001);
    chk("R4 retry pages", mem_info, 16'h1E20);
  endtask

  task automatic t_fail();
    do_cmd(8'h40);
    for (int i = 0; i < 4; i++) do_cmd(8'h27);
    chk("R3 pool exhausted", mem_info, 16'h0020);
    do_cmd(8'h20);
    chk("R4 failed result", 16'(alloc_result), 16'h0080);
    chk("R4 no done", 16'(alloc_done), 16'h0000);
    rx_pages_m1 = 3'd0; rx_req = 1'b1; step(); rx_req = 1'b0;
    chk("R8 drop pulse", 16'(rx_drop), 16'h0001);
    chk("R8 nothing queued", fifo_ports, 16'h8080);
    auto_release = 1'b1; tx_ok = 1'b1; tx_done_pkt = 6'd2; tx_done = 1'b1;
    step(); tx_done = 1'b0; auto_release = 1'b0;
    chk("R4 pages back", mem_info, 16'h0820);
    chk("R4 still pending", 16'(alloc_result), 16'h0080);
    step();
    chk("R4 deferred grant", 16'(alloc_result), 16'h0002);
    chk("R4 deferred done", 16'(alloc_done), 16'h0001);
    chk("R4 deferred pages", mem_info, 16'h0720);
    step();
    chk("R4 done one cycle", 16'(alloc_done), 16'h0000);
    do_cmd(8'h27);
    chk("R4 second failure", 16'(alloc_result), 16'h0080);
    enq_pkt = 6'd3; do_cmd(8'hC0);
    do_cmd(8'h40);
    chk("R11 pages", mem_info, 16'h2020);
    chk("R11 queue", 16'(txq_valid), 16'h0000);
    step(); step();
    chk("R11 pending cleared", 16'(alloc_result), 16'h0080);
    chk("R11 no late grant", mem_info, 16'h2020);
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_busy();
    t_alloc();
    t_enqueue();
    t_txdone();
    t_txreset();
    t_rx();
    t_collision();
    t_fail();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule